// File: doc/BRIEF.md
# Converter Enable Control Sequencer

This block decides, cycle by cycle, whether one power converter channel runs. A 2-bit select field picks who governs the channel. With select 00 the register enable bit alone rules. With 01, 10 or 11, one of three external enable pins rules, and the register bit still acts as a master gate. The device power state must also permit operation.

When a pin is in control, its edges are stretched by 4-bit on and off delay values counted in ticks of an external time base. A change made through the register bit or the power state takes effect on the next clock. Once the channel starts, a comparator must report within a parameterised number of clock cycles (one millisecond) that the output has passed its soft-start threshold. If it does not, the channel is forced off and a sticky short-circuit interrupt is raised. The channel then stays off until its enable request is withdrawn and given again.

Top module: `conv_en_seq`

## Requirements
- R1: While `en_reg` is 0 the channel is off: `conv_run` is 0 one clock after `en_reg` is sampled low, whatever `ctl_sel` and `en_pin` hold.
- R2: With `ctl_sel` = 00 and `en_reg` = 1, `conv_run` rises one clock later and the pins have no effect on it.
- R3: `ctl_sel` = 01, 10 and 11 select `en_pin[0]`, `en_pin[1]` and `en_pin[2]`: a high level on the selected pin runs the channel, a low level stops it, and unselected pins have no effect.
- R4: A rising edge of the selected pin starts the channel after `dly_on` ticks: `conv_run` rises at the clock edge of the `dly_on`-th `dly_tick` pulse after the edge is sampled. With `dly_on` = 0 it rises on the next clock.
- R5: A falling edge of the selected pin stops the channel at the clock edge of the `dly_off`-th tick pulse after the edge is sampled. With `dly_off` = 0 it stops on the next clock.
- R6: Switching through `en_reg` is never delayed. Turning it off while a pin is in control stops the channel on the next clock. Turning it on while the selected pin is already high starts the channel on the next clock.
- R7: If the selected pin goes back to its earlier level before a pending start or stop delay expires, the pending action is dropped and `conv_run` keeps its value.
- R8: The channel may run only while `pwr_state` is 01 (standby) or 10 (active). Any other value turns `conv_run` off on the next clock.
- R9: If `vout_ok` has not been seen high within `CYC_PER_MS` clock cycles after `conv_run` rises, `conv_run` falls and `sc_irq` is set on the same edge. `vout_ok` high on any of those edges, including the last one, prevents the fault.
- R10: `sc_irq` is sticky and is cleared by a one-cycle `sc_irq_clr` pulse. A new fault in the same cycle as the clear leaves it set.
- R11: After a fault the channel stays off while the request persists. It can start again only after the request is removed and then applied again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_reg | input | 1 | Register enable bit (master gate) |
| ctl_sel | input | 2 | Control source: 00 register, 01/10/11 pin 0/1/2 |
| en_pin | input | 3 | External enable pins |
| dly_on | input | 4 | Start delay in ticks (pin control only) |
| dly_off | input | 4 | Stop delay in ticks (pin control only) |
| dly_tick | input | 1 | One-cycle time-base pulse for the delays |
| vout_ok | input | 1 | Output is above the soft-start threshold |
| pwr_state | input | 2 | Device state: 00 off, 01 standby, 10 active, 11 transition |
| sc_irq_clr | input | 1 | Clear strobe for the short-circuit flag |
| conv_run | output | 1 | Converter run command |
| sc_irq | output | 1 | Sticky short-circuit interrupt flag |

## Verification
Two events can coincide in one cycle here.

The first pair is the start-up timeout and a software clear of the interrupt flag. The bench leaves the flag set from an earlier fault, starts a channel whose comparator stays low, and pulses `sc_irq_clr` on exactly the edge where the window ends. The flag must stay high while `conv_run` drops.

The second pair is the timeout and the comparator itself. The bench raises `vout_ok` only on that final edge of the window and expects the channel to keep running with no flag.

// File: rtl/conv_seq_pkg.sv
// Package: shared types for the converter enable sequencer.
// Assumes: used by every module of conv_en_seq; holds no logic.
package conv_seq_pkg;

    // Sequencer states: idle, start pending, running, stop pending, faulted
    typedef enum logic [2:0] {
        SQ_OFF = 3'd0,
        SQ_UPW = 3'd1,
        SQ_ON  = 3'd2,
        SQ_DNW = 3'd3,
        SQ_FLT = 3'd4
    } seq_state_e;

    // Device power states; only standby and active permit running
    typedef enum logic [1:0] {
        PS_OFF  = 2'd0,
        PS_STBY = 2'd1,
        PS_ACT  = 2'd2,
        PS_TRAN = 2'd3
    } pwr_state_e;

endpackage

// File: rtl/cseq_src_sel.sv
// Module: cseq_src_sel
// Resolves the enable request from the register bit, the selected pin and
// the power state, and detects edges on the selected pin level.
// Assumes: pins are already synchronised to clk; select 0 means register control.
module cseq_src_sel #(
    parameter int NPIN  = 3,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_reg,
    input  logic [SEL_W-1:0] sel,
    input  logic [NPIN-1:0]  pins,
    input  logic [1:0]       pwr_state,
    output logic             req,
    output logic             pin_mode,
    output logic             pin_lvl,
    output logic             pin_rise,
    output logic             hard_off
);
    import conv_seq_pkg::*;

    logic state_ok;
    logic pin_q;
    logic [NPIN:0] lvl_tab;

    // Build a lookup where entry 0 is unused and entry k is pin k-1
    assign lvl_tab[0] = 1'b0;
    for (genvar g = 0; g < NPIN; g++) begin : g_tab
        assign lvl_tab[g+1] = pins[g];
    end

    // Decode power state permission and the selected pin level
    always_comb begin
        state_ok = (pwr_state == PS_STBY) || (pwr_state == PS_ACT);
        pin_mode = (sel != '0);
        pin_lvl  = 1'b0;
        for (int k = 1; k <= NPIN; k++) begin
            if (int'(sel) == k) pin_lvl = lvl_tab[k];
        end
    end

    // Register the selected level to find its edges
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin_lvl;
    end

    // Combine gating terms into the request and the immediate-off condition
    always_comb begin
        hard_off = !en_reg || !state_ok;
        req      = !hard_off && (!pin_mode || pin_lvl);
        pin_rise = pin_mode && pin_lvl && !pin_q;
    end

endmodule

// File: rtl/cseq_dly_cnt.sv
// Module: cseq_dly_cnt
// Loadable tick-driven down counter shared by the start and stop delays.
// Assumes: tick is a one-cycle pulse; expire is only consulted in wait states.
module cseq_dly_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         expire
);
    logic [W-1:0] cnt;

    // Load on request, otherwise count down one step per tick
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt <= '0;
        else if (load)                cnt <= load_val;
        else if (tick && cnt != '0)   cnt <= cnt - 1'b1;
    end

    // The final tick of a loaded delay ends it
    assign expire = tick && (cnt == W'(1));

    // R4
    // without a load or a tick the count must not move
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(cnt));

endmodule

// File: rtl/cseq_sc_wdog.sv
// Module: cseq_sc_wdog
// Start-up short-circuit watchdog: counts clock cycles while running and
// the threshold comparator has not yet been seen high.
// Assumes: LIM >= 2 is the number of cycles in the allowed window.
module cseq_sc_wdog #(
    parameter int LIM = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic vout_ok,
    output logic fire
);
    localparam int CW = $clog2(LIM + 1);
    localparam logic [CW-1:0] LAST = CW'(LIM - 1);

    logic [CW-1:0] cnt;
    logic          seen;

    // Remember that the output reached its threshold during this run
    always_ff @(posedge clk) begin
        if (!rst_n || !run) seen <= 1'b0;
        else if (vout_ok)   seen <= 1'b1;
    end

    // Count cycles of an unconfirmed run
    always_ff @(posedge clk) begin
        if (!rst_n || !run || seen || vout_ok) cnt <= '0;
        else if (cnt != LAST)                  cnt <= cnt + 1'b1;
    end

    // Window exhausted with no confirmation
    assign fire = run && !seen && !vout_ok && (cnt == LAST);

    // R9
    // the window count never passes its last value
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R9
    // once confirmed, the same run never times out
    no_fire_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && seen) |-> !fire);

endmodule

// File: rtl/cseq_fsm.sv
// Module: cseq_fsm
// Sequencer state machine: applies delays to pin edges, acts at once on
// register or power-state changes, and enters a fault state on timeout.
// Assumes: inputs come from cseq_src_sel, cseq_dly_cnt and cseq_sc_wdog.
module cseq_fsm #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req,
    input  logic         pin_mode,
    input  logic         pin_lvl,
    input  logic         pin_rise,
    input  logic         hard_off,
    input  logic         fire,
    input  logic         expire,
    input  logic [W-1:0] dly_on,
    input  logic [W-1:0] dly_off,
    output logic         load,
    output logic [W-1:0] load_val,
    output logic         run
);
    import conv_seq_pkg::*;

    seq_state_e st, nxt;

    // Next-state and delay-load decision
    always_comb begin
        nxt      = st;
        load     = 1'b0;
        load_val = dly_on;
        case (st)
            SQ_OFF: begin
                if (req) begin
                    if (pin_mode && pin_rise && dly_on != '0) begin
                        nxt  = SQ_UPW;
                        load = 1'b1;
                    end else begin
                        nxt = SQ_ON;
                    end
                end
            end
            SQ_UPW: begin
                if (!req)                      nxt = SQ_OFF;
                else if (!pin_mode || expire)  nxt = SQ_ON;
            end
            SQ_ON: begin
                if (fire)          nxt = SQ_FLT;
                else if (hard_off) nxt = SQ_OFF;
                else if (pin_mode && !pin_lvl) begin
                    if (dly_off == '0) nxt = SQ_OFF;
                    else begin
                        nxt      = SQ_DNW;
                        load     = 1'b1;
                        load_val = dly_off;
                    end
                end
            end
            SQ_DNW: begin
                if (fire)                      nxt = SQ_FLT;
                else if (hard_off)             nxt = SQ_OFF;
                else if (!pin_mode || pin_lvl) nxt = SQ_ON;
                else if (expire)               nxt = SQ_OFF;
            end
            SQ_FLT: begin
                if (!req) nxt = SQ_OFF;
            end
            default: nxt = SQ_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= SQ_OFF;
        else        st <= nxt;
    end

    assign run = (st == SQ_ON) || (st == SQ_DNW);

    // R7
    // a withdrawn request during a pending start returns to idle
    up_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_UPW && !req) |=> (st == SQ_OFF));

    // R11
    // a faulted channel holds off while its request persists
    flt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_FLT && req) |=> (st == SQ_FLT));

    // R5
    // an expiring stop delay with the pin still low ends the run
    dn_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_DNW && !fire && !hard_off && pin_mode && !pin_lvl && expire) |=> !run);

endmodule

// File: rtl/conv_en_seq.sv
// Module: conv_en_seq (top)
// Enable sequencer for one converter channel: source selection, pin-edge
// delays, start-up short-circuit watchdog and a sticky interrupt flag.
// Assumes: all inputs synchronous to clk; CYC_PER_MS clock cycles per ms.
module conv_en_seq #(
    parameter int CYC_PER_MS = 200000,
    parameter int DLY_W      = 4,
    parameter int NPIN       = 3,
    parameter int SEL_W      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_reg,
    input  logic [SEL_W-1:0] ctl_sel,
    input  logic [NPIN-1:0]  en_pin,
    input  logic [DLY_W-1:0] dly_on,
    input  logic [DLY_W-1:0] dly_off,
    input  logic             dly_tick,
    input  logic             vout_ok,
    input  logic [1:0]       pwr_state,
    input  logic             sc_irq_clr,
    output logic             conv_run,
    output logic             sc_irq
);
    import conv_seq_pkg::*;

    logic             req, pin_mode, pin_lvl, pin_rise, hard_off;
    logic             fire, expire, load;
    logic [DLY_W-1:0] load_val;
    logic             irq_q;

    cseq_src_sel #(.NPIN(NPIN), .SEL_W(SEL_W)) u_src (
        .clk(clk), .rst_n(rst_n), .en_reg(en_reg), .sel(ctl_sel),
        .pins(en_pin), .pwr_state(pwr_state), .req(req),
        .pin_mode(pin_mode), .pin_lvl(pin_lvl), .pin_rise(pin_rise),
        .hard_off(hard_off)
    );

    cseq_dly_cnt #(.W(DLY_W)) u_dly (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
        .tick(dly_tick), .expire(expire)
    );

    cseq_sc_wdog #(.LIM(CYC_PER_MS)) u_wdog (
        .clk(clk), .rst_n(rst_n), .run(conv_run), .vout_ok(vout_ok),
        .fire(fire)
    );

    cseq_fsm #(.W(DLY_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req(req), .pin_mode(pin_mode),
        .pin_lvl(pin_lvl), .pin_rise(pin_rise), .hard_off(hard_off),
        .fire(fire), .expire(expire), .dly_on(dly_on), .dly_off(dly_off),
        .load(load), .load_val(load_val), .run(conv_run)
    );

    // Sticky interrupt: a new fault outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)          irq_q <= 1'b0;
        else if (fire)       irq_q <= 1'b1;
        else if (sc_irq_clr) irq_q <= 1'b0;
    end

    assign sc_irq = irq_q;

    // R1
    // a low register bit stops the channel by the next clock
    reg_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_reg |=> !conv_run);

    // R8
    // a power state other than standby or active stops the channel
    pwr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwr_state == PS_STBY || pwr_state == PS_ACT) |=> !conv_run);

    // R10
    // the flag holds unless a clear arrives
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_irq && !sc_irq_clr) |=> sc_irq);

    // R9
    // a timeout raises the flag and stops the channel together
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (sc_irq && !conv_run));

endmodule

// File: tb/conv_en_seq_tb.sv
`timescale 1ns/1ps
module conv_en_seq_tb;
    localparam int LIM = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_reg = 1'b0;
    logic [1:0] ctl_sel = 2'b00;
    logic [2:0] en_pin = 3'b000;
    logic [3:0] dly_on = 4'd0;
    logic [3:0] dly_off = 4'd0;
    logic       dly_tick = 1'b0;
    logic       vout_ok = 1'b1;
    logic [1:0] pwr_state = 2'b10;
    logic       sc_irq_clr = 1'b0;
    logic       conv_run, sc_irq;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int    at;
        bit    run;
        bit    irq;
        string tag;
    } exp_t;
    exp_t sb[$];
    exp_t e;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    conv_en_seq #(.CYC_PER_MS(LIM)) u_dut (
        .clk(clk), .rst_n(rst_n), .en_reg(en_reg), .ctl_sel(ctl_sel),
        .en_pin(en_pin), .dly_on(dly_on), .dly_off(dly_off),
        .dly_tick(dly_tick), .vout_ok(vout_ok), .pwr_state(pwr_state),
        .sc_irq_clr(sc_irq_clr), .conv_run(conv_run), .sc_irq(sc_irq)
    );

    // Monitor: pop due expectations and compare just after each falling edge
    always @(negedge clk) begin
        #1;
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            e = sb.pop_front();
            checks++;
            if (conv_run !== e.run || sc_irq !== e.irq) begin
                errors++;
                $display("FAIL %s: run/irq actual %b/%b expected %b/%b",
                         e.tag, conv_run, sc_irq, e.run, e.irq);
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver side: queue an expectation for the current cycle
    task automatic expect_o(bit run, bit irq, string tag);
        exp_t x;
        x.at = cyc; x.run = run; x.irq = irq; x.tag = tag;
        sb.push_back(x);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            dly_tick = 1'b1; step(1);
            dly_tick = 1'b0; step(1);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run/irq actual %b/%b expected completion", conv_run, sc_irq);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // reset holds outputs low even with an enabling request
        en_reg = 1'b1;
        step(3);
        expect_o(0, 0, "RST");
        rst_n = 1'b1;
        en_reg = 1'b0;
        step(2);
        expect_o(0, 0, "RST idle");

        // R2 register control, pins ignored
        ctl_sel = 2'b00; en_reg = 1'b1; step(1);
        expect_o(1, 0, "R2 start next clock");
        en_pin = 3'b111; step(2);
        expect_o(1, 0, "R2 pins high ignored");
        en_pin = 3'b000; step(2);
        expect_o(1, 0, "R2 pins low ignored");

        // R8 power state gating
        pwr_state = 2'b00; step(1);
        expect_o(0, 0, "R8 off state");
        pwr_state = 2'b01; step(1);
        expect_o(1, 0, "R8 standby runs");
        pwr_state = 2'b11; step(1);
        expect_o(0, 0, "R8 transition state");
        pwr_state = 2'b10; step(1);
        expect_o(1, 0, "R8 active runs");

        // R1 register bit low overrides everything
        en_reg = 1'b0; ctl_sel = 2'b01; en_pin = 3'b111; step(1);
        expect_o(0, 0, "R1 disabled");
        ctl_sel = 2'b11; step(2);
        expect_o(0, 0, "R1 disabled other select");

        // R3 pin selection with zero delays
        en_pin = 3'b000; ctl_sel = 2'b10; en_reg = 1'b1; step(2);
        en_pin = 3'b101; step(2);
        expect_o(0, 0, "R3 unselected pins ignored");
        en_pin = 3'b010; step(1);
        expect_o(1, 0, "R3 pin 1 high runs");
        en_pin = 3'b111; step(1);
        expect_o(1, 0, "R3 still running");
        ctl_sel = 2'b11; en_pin = 3'b011; step(1);
        expect_o(0, 0, "R3 pin 2 low stops");

        // R4 start delay of three ticks on pin 0
        en_pin = 3'b000; ctl_sel = 2'b01; dly_on = 4'd3; dly_off = 4'd2; step(2);
        en_pin = 3'b001; step(1);
        expect_o(0, 0, "R4 delay pending");
        ticks(2);
        expect_o(0, 0, "R4 before last tick");
        dly_tick = 1'b1; step(1); dly_tick = 1'b0;
        expect_o(1, 0, "R4 run after third tick");

        // R5 stop delay of two ticks
        en_pin = 3'b000; step(1);
        expect_o(1, 0, "R5 stop pending");
        ticks(1);
        expect_o(1, 0, "R5 before last tick");
        dly_tick = 1'b1; step(1); dly_tick = 1'b0;
        expect_o(0, 0, "R5 stop after second tick");

        // R7 start cancelled by pin returning low
        en_pin = 3'b001; step(1);
        ticks(1);
        en_pin = 3'b000; step(1);
        ticks(5);
        expect_o(0, 0, "R7 start cancelled");

        // R4 zero start delay
        dly_on = 4'd0; en_pin = 3'b001; step(1);
        expect_o(1, 0, "R4 zero delay");

        // R7 stop cancelled by pin returning high
        en_pin = 3'b000; step(1);
        ticks(1);
        en_pin = 3'b001; step(1);
        ticks(4);
        expect_o(1, 0, "R7 stop cancelled");

        // R6 register writes act at once in pin mode
        en_reg = 1'b0; step(1);
        expect_o(0, 0, "R6 immediate off");
        dly_on = 4'd3; en_reg = 1'b1; step(1);
        expect_o(1, 0, "R6 immediate on, pin already high");

        // R9 timeout with comparator low
        en_reg = 1'b0; ctl_sel = 2'b00; step(2);
        vout_ok = 1'b0; en_reg = 1'b1; step(1);
        expect_o(1, 0, "R9 started");
        step(LIM - 1);
        expect_o(1, 0, "R9 last cycle of window");
        step(1);
        expect_o(0, 1, "R9 timeout fault");

        // R11 stays off until request removed and reapplied
        vout_ok = 1'b1; step(4);
        expect_o(0, 1, "R11 held off");
        en_reg = 1'b0; step(1);
        en_reg = 1'b1; step(1);
        expect_o(1, 1, "R11 restart after reapply");

        // R10 collision: clear on the fault edge, set wins
        en_reg = 1'b0; step(2);
        vout_ok = 1'b0; en_reg = 1'b1; step(1);
        step(LIM - 1);
        sc_irq_clr = 1'b1; step(1); sc_irq_clr = 1'b0;
        expect_o(0, 1, "R10 set wins over clear");
        sc_irq_clr = 1'b1; step(1); sc_irq_clr = 1'b0;
        expect_o(0, 0, "R10 clear strobe");
        step(2);
        expect_o(0, 0, "R10 stays clear");

        // R9 comparator arrives on the final edge of the window
        en_reg = 1'b0; step(2);
        en_reg = 1'b1; step(1);
        step(LIM - 1);
        vout_ok = 1'b1; step(1);
        expect_o(1, 0, "R9 last-edge confirm");
        step(LIM + 5);
        expect_o(1, 0, "R9 no later fault");

        step(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule